// File: doc/BRIEF.md
# Paired-Clock Multi-Channel PWM Controller

This block generates up to sixteen pulse-width-modulated outputs and is programmed through a small word-addressed register bus. Channels are grouped in pairs. Each pair owns one clock setting. That setting picks one of two tick enables, a slow oscillator tick or a bus-clock tick, and divides the chosen tick by a power of two. Each channel then divides the pair tick again with an 8-bit prescaler. The divided tick drives a 16-bit period counter. The channel output holds its active level while the counter is below the programmed active count.

Both tick sources are modelled as enables in the one clock domain. A channel drives its pin only while both its enable bit and its gate bit are set. Otherwise the output enable is low, which models a tri-stated pin. A per-channel bypass bit replaces the PWM waveform with a square wave that toggles on every pair tick. Register writes act at once: a running period is not allowed to finish before new settings apply.

Top module: `pwmbank_top`

## Requirements
- R1: After reset every register reads as zero, and every pwmOe and pwmOut bit is low.
- R2: Read data appears on busRdData in the cycle after busRdEn and is zero otherwise. The register map uses byte addresses:
  - The pair-p clock setting is at 0x20+4p, with the source in bits [8:7] and the divider exponent in bits [3:0].
  - Gate bits are at 0x40 bit c, and bypass bits are at 0x40 bit c+16.
  - Enable bits are at 0x80 bit c.
  - The channel-c control register is at 0x100+0x20c, with the prescaler in bits [7:0] and the active level in bit 8.
  - The channel-c period register is at 0x104+0x20c, with the period minus one in bits [31:16] and the active count in bits [15:0].
  - All other bits read as zero.
- R3: A channel drives its output (pwmOe high) only when both its enable bit and its gate bit are set. Otherwise pwmOe and pwmOut are both low.
- R4: A running channel repeats a period of E+1 channel ticks. For counter values below the active count A the output shows the active level: high when bit 8 is 1, low when bit 8 is 0. For the other counter values it shows the opposite level. If A > E the output stays at the active level.
- R5: A source field of zero clocks the pair from slowTick. Any nonzero source value clocks the pair from busTick. With no tick and no write, the outputs do not change.
- R6: The pair divider produces one pair tick per 2^m selected ticks. Exponent values above 8 act as 8.
- R7: The prescaler produces one channel tick per P+1 pair ticks.
- R8: With its bypass bit set, a running channel's output toggles on every pair tick instead of showing the PWM waveform.
- R9: Addresses outside the map, misaligned addresses, and registers of channels at or above NUM_CH read as zero, and writes to them change no register.
- R10: Channels 2p and 2p+1 take their timing from the pair-p clock setting only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busWrEn | input | 1 | Write strobe |
| busRdEn | input | 1 | Read strobe |
| busAddr | input | ADDR_W | Byte address |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data, one cycle after busRdEn |
| slowTick | input | 1 | Slow oscillator tick enable |
| busTick | input | 1 | Bus-clock tick enable |
| pwmOut | output | NUM_CH | Channel output levels |
| pwmOe | output | NUM_CH | Channel output enables (low = tri-stated) |

## Verification
A wrong divider or prescaler state shows up as a wrong spacing between rising output edges. So the bench measures whole periods after each clock-setting change, and it skips the first, disturbed interval. A wrong period-counter state shows up within one period as a wrong high/low pattern, which is compared cycle by cycle from the enabling write. A wrong decode shows up on the very next read, either as a missing field or as a stray write into a neighbouring register.

// File: rtl/pwmbank_pkg.sv
package pwmbank_pkg;
  localparam int CNT_W        = 16;
  localparam int PRE_W        = 8;
  localparam int SRC_W        = 2;
  localparam int DIVEXP_W     = 4;
  localparam int DIVEXP_MAX   = 8;
  localparam int DIV_W        = DIVEXP_MAX;
  localparam int MAX_CH       = 16;

  localparam int PAIR_BASE    = 'h20;
  localparam int PAIR_STRIDE  = 'h4;
  localparam int GATE_ADDR    = 'h40;
  localparam int BYPASS_SHIFT = 16;
  localparam int EN_ADDR      = 'h80;
  localparam int CHAN_BASE    = 'h100;
  localparam int CHAN_STRIDE  = 'h20;
  localparam int PERIOD_OFS   = 'h4;

  localparam int SRC_LO       = 7;
  localparam int LVL_BIT      = 8;

  typedef struct packed {
    logic [SRC_W-1:0]    src;
    logic [DIVEXP_W-1:0] divExp;
  } pairSet_t;

  typedef struct packed {
    logic             actLevel;
    logic [PRE_W-1:0] prescale;
    logic [CNT_W-1:0] periodM1;
    logic [CNT_W-1:0] actCount;
  } chanSet_t;

  // strobes handed from the datapath level to one channel
  typedef struct packed {
    logic run;
    logic bypass;
    logic tick;
  } chanStb_t;
endpackage

// File: rtl/pwmbank_pairdiv.sv
module pwmbank_pairdiv
  import pwmbank_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     slowTick,
  input  logic     busTick,
  input  pairSet_t setting,
  output logic     pairTick
);
  logic                selTick;
  logic [DIVEXP_W-1:0] expEff;
  logic [DIV_W-1:0]    mask;
  logic [DIV_W-1:0]    divCnt;

  assign selTick = (|setting.src) ? busTick : slowTick;
  assign expEff  = (setting.divExp > DIVEXP_W'(DIVEXP_MAX)) ? DIVEXP_W'(DIVEXP_MAX) : setting.divExp;
  assign mask    = DIV_W'((1 << expEff) - 1);
  assign pairTick = selTick && ((divCnt & mask) == mask);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        divCnt <= '0;
    else if (selTick) divCnt <= divCnt + DIV_W'(1);
  end
endmodule

// File: rtl/pwmbank_chan.sv
module pwmbank_chan
  import pwmbank_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  chanStb_t stb,
  input  chanSet_t setting,
  output logic     out,
  output logic     oe
);
  logic [PRE_W-1:0] preCnt;
  logic [CNT_W-1:0] cnt;
  logic             tog;
  logic             activeNow;
  logic             level;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      preCnt <= '0;
      cnt    <= '0;
      tog    <= 1'b0;
    end else if (!stb.run) begin
      preCnt <= '0;
      cnt    <= '0;
      tog    <= 1'b0;
    end else if (stb.tick) begin
      tog <= ~tog;
      if (preCnt >= setting.prescale) begin
        preCnt <= '0;
        cnt    <= (cnt >= setting.periodM1) ? '0 : cnt + CNT_W'(1);
      end else begin
        preCnt <= preCnt + PRE_W'(1);
      end
    end
  end

  assign activeNow = cnt < setting.actCount;
  assign level     = stb.bypass ? tog : (activeNow ? setting.actLevel : ~setting.actLevel);
  assign out       = stb.run & level;
  assign oe        = stb.run;
endmodule

// File: rtl/pwmbank_regs.sv
module pwmbank_regs
  import pwmbank_pkg::*;
#(
  parameter  int NUM_CH   = 4,
  parameter  int ADDR_W   = 12,
  localparam int NUM_PAIR = (NUM_CH + 1) / 2
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          busWrEn,
  input  logic                          busRdEn,
  input  logic [ADDR_W-1:0]             busAddr,
  input  logic [31:0]                   busWrData,
  output logic [31:0]                   busRdData,
  output pairSet_t [NUM_PAIR-1:0]       pairSet,
  output chanSet_t [NUM_CH-1:0]         chanSet,
  output logic [NUM_CH-1:0]             enVec,
  output logic [NUM_CH-1:0]             gateVec,
  output logic [NUM_CH-1:0]             bypassVec
);
  logic [31:0] rdNext;

  function automatic logic [ADDR_W-1:0] pairAddr(int p);
    return ADDR_W'(PAIR_BASE + PAIR_STRIDE * p);
  endfunction

  function automatic logic [ADDR_W-1:0] ctlAddr(int c);
    return ADDR_W'(CHAN_BASE + CHAN_STRIDE * c);
  endfunction

  function automatic logic [ADDR_W-1:0] perAddr(int c);
    return ADDR_W'(CHAN_BASE + CHAN_STRIDE * c + PERIOD_OFS);
  endfunction

  always_comb begin
    rdNext = '0;
    for (int p = 0; p < NUM_PAIR; p++) begin
      if (busAddr == pairAddr(p)) begin
        rdNext[SRC_LO +: SRC_W]  = pairSet[p].src;
        rdNext[DIVEXP_W-1:0]     = pairSet[p].divExp;
      end
    end
    if (busAddr == ADDR_W'(GATE_ADDR)) begin
      rdNext[NUM_CH-1:0]              = gateVec;
      rdNext[BYPASS_SHIFT +: NUM_CH]  = bypassVec;
    end
    if (busAddr == ADDR_W'(EN_ADDR)) rdNext[NUM_CH-1:0] = enVec;
    for (int c = 0; c < NUM_CH; c++) begin
      if (busAddr == ctlAddr(c)) begin
        rdNext[LVL_BIT]     = chanSet[c].actLevel;
        rdNext[PRE_W-1:0]   = chanSet[c].prescale;
      end
      if (busAddr == perAddr(c)) rdNext = {chanSet[c].periodM1, chanSet[c].actCount};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busRdData <= '0;
      pairSet   <= '0;
      chanSet   <= '0;
      enVec     <= '0;
      gateVec   <= '0;
      bypassVec <= '0;
    end else begin
      busRdData <= busRdEn ? rdNext : '0;
      if (busWrEn) begin
        for (int p = 0; p < NUM_PAIR; p++) begin
          if (busAddr == pairAddr(p)) begin
            pairSet[p].src    <= busWrData[SRC_LO +: SRC_W];
            pairSet[p].divExp <= busWrData[DIVEXP_W-1:0];
          end
        end
        if (busAddr == ADDR_W'(GATE_ADDR)) begin
          gateVec   <= busWrData[NUM_CH-1:0];
          bypassVec <= busWrData[BYPASS_SHIFT +: NUM_CH];
        end
        if (busAddr == ADDR_W'(EN_ADDR)) enVec <= busWrData[NUM_CH-1:0];
        for (int c = 0; c < NUM_CH; c++) begin
          if (busAddr == ctlAddr(c)) begin
            chanSet[c].actLevel <= busWrData[LVL_BIT];
            chanSet[c].prescale <= busWrData[PRE_W-1:0];
          end
          if (busAddr == perAddr(c)) begin
            chanSet[c].periodM1 <= busWrData[31:16];
            chanSet[c].actCount <= busWrData[15:0];
          end
        end
      end
    end
  end
endmodule

// File: rtl/pwmbank_datapath.sv
module pwmbank_datapath
  import pwmbank_pkg::*;
#(
  parameter  int NUM_CH   = 4,
  localparam int NUM_PAIR = (NUM_CH + 1) / 2
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    slowTick,
  input  logic                    busTick,
  input  pairSet_t [NUM_PAIR-1:0] pairSet,
  input  chanSet_t [NUM_CH-1:0]   chanSet,
  input  logic [NUM_CH-1:0]       enVec,
  input  logic [NUM_CH-1:0]       gateVec,
  input  logic [NUM_CH-1:0]       bypassVec,
  output logic [NUM_CH-1:0]       pwmOut,
  output logic [NUM_CH-1:0]       pwmOe
);
  logic [NUM_PAIR-1:0] pairTick;
  chanStb_t [NUM_CH-1:0] stb;

  for (genvar p = 0; p < NUM_PAIR; p++) begin : gPair
    pwmbank_pairdiv uDiv (
      .clk      (clk),
      .rstN     (rstN),
      .slowTick (slowTick),
      .busTick  (busTick),
      .setting  (pairSet[p]),
      .pairTick (pairTick[p])
    );
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : gChan
    assign stb[c].run    = enVec[c] & gateVec[c];
    assign stb[c].bypass = bypassVec[c];
    assign stb[c].tick   = pairTick[c / 2];
    pwmbank_chan uChan (
      .clk     (clk),
      .rstN    (rstN),
      .stb     (stb[c]),
      .setting (chanSet[c]),
      .out     (pwmOut[c]),
      .oe      (pwmOe[c])
    );
  end
endmodule

// File: rtl/pwmbank_top.sv
module pwmbank_top
  import pwmbank_pkg::*;
#(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic              busRdEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              slowTick,
  input  logic              busTick,
  output logic [NUM_CH-1:0] pwmOut,
  output logic [NUM_CH-1:0] pwmOe
);
  localparam int NUM_PAIR = (NUM_CH + 1) / 2;

  pairSet_t [NUM_PAIR-1:0] pairSet;
  chanSet_t [NUM_CH-1:0]   chanSet;
  logic [NUM_CH-1:0]       enVec;
  logic [NUM_CH-1:0]       gateVec;
  logic [NUM_CH-1:0]       bypassVec;

  pwmbank_regs #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uRegs (
    .clk       (clk),
    .rstN      (rstN),
    .busWrEn   (busWrEn),
    .busRdEn   (busRdEn),
    .busAddr   (busAddr),
    .busWrData (busWrData),
    .busRdData (busRdData),
    .pairSet   (pairSet),
    .chanSet   (chanSet),
    .enVec     (enVec),
    .gateVec   (gateVec),
    .bypassVec (bypassVec)
  );

  pwmbank_datapath #(.NUM_CH(NUM_CH)) uData (
    .clk       (clk),
    .rstN      (rstN),
    .slowTick  (slowTick),
    .busTick   (busTick),
    .pairSet   (pairSet),
    .chanSet   (chanSet),
    .enVec     (enVec),
    .gateVec   (gateVec),
    .bypassVec (bypassVec),
    .pwmOut    (pwmOut),
    .pwmOe     (pwmOe)
  );
endmodule

// File: rtl/pwmbank_chk.sv
module pwmbank_chk #(
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic              busRdEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [31:0]       busRdData,
  input logic              slowTick,
  input logic              busTick,
  input logic [NUM_CH-1:0] pwmOut,
  input logic [NUM_CH-1:0] pwmOe,
  input logic [NUM_CH-1:0] enVec,
  input logic [NUM_CH-1:0] gateVec
);
  AST_OE_NEEDS_EN_GATE: assert property (@(posedge clk) disable iff (!rstN)
    (pwmOe & ~(enVec & gateVec)) == '0); // R3

  AST_OUT_LOW_WHEN_FLOAT: assert property (@(posedge clk) disable iff (!rstN)
    (pwmOut & ~pwmOe) == '0); // R3

  AST_RDATA_ONLY_AFTER_READ: assert property (@(posedge clk) disable iff (!rstN)
    !busRdEn |=> busRdData == '0); // R2

  AST_LOW_ADDR_READS_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (busRdEn && busAddr < ADDR_W'('h20)) |=> busRdData == '0); // R9

  AST_NO_TICK_NO_CHANGE: assert property (@(posedge clk) disable iff (!rstN)
    (!slowTick && !busTick && !busWrEn) |=> $stable(pwmOut)); // R5
endmodule

bind pwmbank_top pwmbank_chk #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) uChk (
  .clk       (clk),
  .rstN      (rstN),
  .busWrEn   (busWrEn),
  .busRdEn   (busRdEn),
  .busAddr   (busAddr),
  .busRdData (busRdData),
  .slowTick  (slowTick),
  .busTick   (busTick),
  .pwmOut    (pwmOut),
  .pwmOe     (pwmOe),
  .enVec     (enVec),
  .gateVec   (gateVec)
);

// File: tb/sim_pwmbank_top.sv
module sim_pwmbank_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_CH     = 4;
  localparam int ADDR_W     = 12;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              busWrEn = 1'b0;
  logic              busRdEn = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic              slowTick = 1'b0;
  logic              busTick = 1'b1;
  logic [NUM_CH-1:0] pwmOut;
  logic [NUM_CH-1:0] pwmOe;

  int checks = 0;
  int errors = 0;
  int cycle  = 0;

  typedef struct {
    int          due;
    bit          isRead;
    int          ch;
    logic [31:0] val;
    string       req;
  } expItem_t;
  expItem_t expQ[$];

  pwmbank_top #(.NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busRdEn(busRdEn),
    .busAddr(busAddr), .busWrData(busWrData), .busRdData(busRdData),
    .slowTick(slowTick), .busTick(busTick), .pwmOut(pwmOut), .pwmOe(pwmOe)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;
  always @(posedge clk) cycle++;

  task automatic checkVal(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h (cycle %0d)", req, act, exp, cycle);
    end
  endtask

  // monitor: compares due items a quarter period after each falling edge
  always @(negedge clk) begin
    #(CLK_PERIOD / 4);
    while (expQ.size() > 0 && expQ[0].due <= cycle) begin
      expItem_t it;
      it = expQ.pop_front();
      if (it.isRead) checkVal(it.req, busRdData, it.val);
      else           checkVal(it.req, 32'(pwmOut[it.ch]), it.val);
    end
  end

  task automatic busWrite(int addr, logic [31:0] data);
    busWrEn = 1'b1; busAddr = ADDR_W'(addr); busWrData = data;
    @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(int addr, logic [31:0] exp, string req);
    expItem_t it;
    busRdEn = 1'b1; busAddr = ADDR_W'(addr);
    it.due = cycle + 1; it.isRead = 1'b1; it.ch = 0; it.val = exp; it.req = req;
    expQ.push_back(it);
    @(negedge clk);
    busRdEn = 1'b0;
  endtask

  // expected waveform from the enabling write onward (counter starts at 0)
  task automatic expectWave(int ch, int n, int ent, int act, bit lvl, string req);
    for (int j = 0; j < n; j++) begin
      expItem_t it;
      it.due = cycle + j; it.isRead = 1'b0; it.ch = ch;
      it.val = (((j % (ent + 1)) < act) ? lvl : !lvl) ? 32'd1 : 32'd0;
      it.req = req;
      expQ.push_back(it);
    end
    repeat (n) @(negedge clk);
  endtask

  // spacing between rising edges, skipping the first interval
  task automatic measurePeriod(int ch, int expP, string req);
    int t[3];
    int got = 0;
    int waited = 0;
    logic prev = pwmOut[ch];
    while (got < 3 && waited < 5000) begin
      @(negedge clk);
      waited++;
      if (!prev && pwmOut[ch]) begin t[got] = cycle; got++; end
      prev = pwmOut[ch];
    end
    if (got < 3) checkVal(req, 32'd0, 32'(expP));
    else         checkVal(req, 32'(t[2] - t[1]), 32'(expP));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkVal("R1", 32'(pwmOe), 32'd0);
    checkVal("R1", 32'(pwmOut), 32'd0);
    busRead('h20, 0, "R1");
    busRead('h40, 0, "R1");
    busRead('h80, 0, "R1");
    busRead('h100, 0, "R1");
    busRead('h164, 0, "R1");

    // R2 field placement
    busWrite('h24, 32'hFFFF_FFFF);
    busRead('h24, 32'h0000_018F, "R2");
    busWrite('h120, 32'hFFFF_FFFF);
    busRead('h120, 32'h0000_01FF, "R2");
    busWrite('h164, 32'h1234_5678);
    busRead('h164, 32'h1234_5678, "R2");
    busWrite('h40, 32'hFFFF_FFFF);
    busRead('h40, 32'h000F_000F, "R2");
    busWrite('h40, 0);
    busWrite('h24, 0);
    busWrite('h120, 0);
    busWrite('h164, 0);

    // R9 unmapped / misaligned / beyond NUM_CH
    busWrite('h44, 32'hFFFF_FFFF);
    busRead('h44, 0, "R9");
    busRead('h40, 0, "R9");
    busWrite('h102, 32'hFFFF_FFFF);
    busRead('h100, 0, "R9");
    busWrite('h180, 32'hFFFF_FFFF);
    busRead('h180, 0, "R9");
    busRead('h24, 0, "R9");

    // channel 0 setup: bus tick source, E=3, A=2, active high
    busWrite('h20, 32'h0000_0080);
    busWrite('h104, 32'h0003_0002);
    busWrite('h100, 32'h0000_0100);

    // R3 enable without gate, gate without enable
    busWrite('h80, 32'h1);
    repeat (2) @(negedge clk);
    checkVal("R3", 32'(pwmOe[0]), 0);
    checkVal("R3", 32'(pwmOut[0]), 0);
    busWrite('h80, 0);
    busWrite('h40, 32'h1);
    repeat (2) @(negedge clk);
    checkVal("R3", 32'(pwmOe[0]), 0);

    // R4 waveform, active high
    busWrite('h80, 32'h1);
    checkVal("R3", 32'(pwmOe[0]), 1);
    expectWave(0, 10, 3, 2, 1'b1, "R4");
    // R4 active low
    busWrite('h80, 0);
    busWrite('h100, 0);
    busWrite('h80, 32'h1);
    expectWave(0, 10, 3, 2, 1'b0, "R4");
    // R4 active count above period: constant active
    busWrite('h80, 0);
    busWrite('h100, 32'h0000_0100);
    busWrite('h104, 32'h0003_0007);
    busWrite('h80, 32'h1);
    expectWave(0, 8, 3, 7, 1'b1, "R4");
    busWrite('h104, 32'h0003_0002);

    // R5 source select
    busWrite('h80, 0);
    busWrite('h20, 0);
    busWrite('h80, 32'h1);
    expectWave(0, 8, 3, 8, 1'b1, "R5");  // slow tick idle: frozen active
    slowTick = 1'b1;
    measurePeriod(0, 4, "R5");
    slowTick = 1'b0;
    busWrite('h20, 32'h0000_0100);
    measurePeriod(0, 4, "R5");

    // R7 prescaler
    busWrite('h100, 32'h0000_0102);
    measurePeriod(0, 12, "R7");
    busWrite('h100, 32'h0000_0100);

    // R6 divider and saturation
    busWrite('h20, 32'h0000_0082);
    measurePeriod(0, 16, "R6");
    busWrite('h104, 32'h0001_0001);
    busWrite('h20, 32'h0000_0088);
    measurePeriod(0, 512, "R6");
    busWrite('h20, 32'h0000_008C);
    measurePeriod(0, 512, "R6");
    busRead('h20, 32'h0000_008C, "R6");

    // R8 bypass
    busWrite('h20, 32'h0000_0080);
    busWrite('h40, 32'h0001_0001);
    measurePeriod(0, 2, "R8");
    busWrite('h20, 32'h0000_0082);
    measurePeriod(0, 8, "R8");
    busWrite('h40, 32'h1);
    busWrite('h80, 0);

    // R10 pair sharing: ch1 on pair 0 (m=2), ch2 on pair 1 (m=0)
    busWrite('h24, 32'h0000_0080);
    busWrite('h124, 32'h0003_0002);
    busWrite('h120, 32'h0000_0100);
    busWrite('h144, 32'h0003_0002);
    busWrite('h140, 32'h0000_0100);
    busWrite('h40, 32'h6);
    busWrite('h80, 32'h6);
    measurePeriod(1, 16, "R10");
    measurePeriod(2, 4, "R10");

    repeat (3) @(negedge clk);
    if (expQ.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", expQ.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule